// File: doc/BRIEF.md
# Packet Number Queue Bank

This block keeps the packet numbers that wait between a shared packet buffer and the serial bus. It holds one short transmit queue per endpoint and one deeper receive queue shared by all endpoints. Packet numbers are small handles into the buffer. No packet data passes through the block, and it does no allocation.

Firmware first writes an endpoint number into a select register. It then pushes transmit packet numbers, and each one lands in the queue of that endpoint. The bus engine reads the head packet number of the endpoint it is serving. When a packet has gone out successfully, the bus engine pops that head. In the other direction the bus engine pushes the packet number of each received packet, and the block acknowledges the push only if there is room. Firmware drains the receive queue from its head.

The block reports per-endpoint empty and full status, packed four endpoints per byte. It raises one-cycle events for a received packet, a transmitted packet and an enabled endpoint queue that has drained. It also keeps two sticky error flags, one for a refused push and one for a pop from an empty queue.

Top module: `pkt_num_queues`

## Requirements
- R1: There are 16 transmit queues, one per endpoint, and each holds up to 5 packet numbers in first-in first-out order. `bus_head_pn` shows the oldest entry of the queue selected by `bus_ep` in the same cycle.
- R2: A firmware push (`fw_push`) goes to the endpoint held in the select register. The select register resets to 0 and loads `sel_ep` on `sel_wr`. A push in the same cycle as a select write still uses the old select value.
- R3: A push to a full queue, transmit or receive, is dropped and leaves the queue unchanged. It sets `err_push_full`, which then stays set until reset.
- R4: A pop from an empty queue, whether a bus pop or a firmware receive pop, is dropped. It sets `err_pop_empty`, which then stays set until reset.
- R5: The receive queue holds up to 16 packet numbers in first-in first-out order. `rx_ack` is high in the cycle of `hw_rx_push` exactly when the queue is not full. A refused push is not acknowledged. `rx_count` gives the number of entries held.
- R6: `ev_rx` pulses for one cycle, in the cycle after each acknowledged receive push.
- R7: `ev_tx` pulses for one cycle, in the cycle after each bus pop that removes an entry.
- R8: `ev_tx_empty` pulses in the cycle after a bus pop that leaves its queue empty, but only if that endpoint's bit in `ep_tx_en` is set. A disabled endpoint never raises it.
- R9: `tx_stat` packs two bits per endpoint. Endpoint e uses bit 2e, which is set when its queue is empty, and bit 2e+1, which is set when its queue holds 5 entries. Status byte k therefore covers endpoints 4k to 4k+3.
- R10: After reset every queue is empty, `tx_stat` has all even bits set and all odd bits clear, `rx_count` is 0, and all events and error flags are low.
- R11: A push and a pop on the same queue in the same cycle are both judged on the occupancy before that cycle. On a partly filled queue both take effect and the count does not change. On a full queue the pop takes effect and the push is refused. On an empty queue the push takes effect and the pop is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Load the endpoint select register |
| sel_ep | input | 4 | New endpoint select value |
| fw_push | input | 1 | Firmware transmit push |
| fw_pn | input | 6 | Packet number to push for transmit |
| ep_tx_en | input | 16 | Per-endpoint enable for the drained event |
| bus_done | input | 1 | Successful transmission; pop the head of `bus_ep` |
| bus_ep | input | 4 | Endpoint being served by the bus engine |
| bus_head_pn | output | 6 | Head packet number of queue `bus_ep` |
| hw_rx_push | input | 1 | Receive packet number offered |
| hw_rx_pn | input | 6 | Received packet number |
| rx_ack | output | 1 | Receive push accepted |
| fw_rx_pop | input | 1 | Firmware pops the receive head |
| rx_head_pn | output | 6 | Head packet number of the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| tx_stat | output | 32 | Packed empty/full status, four endpoints per byte |
| ev_rx | output | 1 | Received packet event |
| ev_tx | output | 1 | Transmitted packet event |
| ev_tx_empty | output | 1 | Enabled endpoint queue drained event |
| err_push_full | output | 1 | Sticky refused-push flag |
| err_pop_empty | output | 1 | Sticky empty-pop flag |

## Verification
The bench fills one endpoint queue to five entries and pushes a sixth. A design whose pointers wrapped too early would overwrite the oldest packet number, and the heads popped afterwards would come out in the wrong order. Push and pop in one cycle are tried on a full queue, a partly filled queue and an empty queue. A design that judged the push after the pop would accept the push on the full queue and report the wrong count. The bench writes the select register and pushes in the same cycle, which catches a design that lets the new select take effect early. Enabled and disabled endpoints are both drained, and a design that ignored the enable would raise the drained event for either one. The receive queue is filled to its sixteenth entry and then offered one more packet. A design that acknowledged that packet would lose it without any sign.

// File: rtl/pnq_pkg.sv
// Shared sizes and the event bundle for the packet number queue bank.
// Assumes the bus engine and firmware run on the same clock as the bank.
package pnq_pkg;
    localparam int PNQ_NUM_EP   = 16;
    localparam int PNQ_TX_DEPTH = 5;
    localparam int PNQ_RX_DEPTH = 16;
    localparam int PNQ_PN_W     = 6;

    typedef struct packed {
        logic rx;        // receive push accepted
        logic tx;        // transmit head popped
        logic tx_drain;  // enabled endpoint queue drained
    } pnq_evt_t;
endpackage

// File: rtl/pnq_fifo.sv
// Circular first-in first-out queue of packet numbers with any depth of 2 or more.
// A push is accepted only when the queue is not full, and a pop only when it is
// not empty. Both are judged on the occupancy before the clock edge.
// Assumes the caller treats push_ok and pop_ok as the only proof of acceptance.
module pnq_fifo #(
    parameter int DEPTH = 5,
    parameter int W     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic            empty,
    output logic            full,
    output logic            push_ok,
    output logic            pop_ok
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    // Storage: write the accepted packet number at the tail.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointers: advance tail on push and head on pop, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    // Occupancy: follow accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
    p_pushpop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/pnq_tx_bank.sv
// One transmit queue per endpoint. Firmware pushes to the selected endpoint and
// the bus engine pops the endpoint it has just served. The bank packs the status
// and flags a pop that leaves an enabled queue empty.
// Assumes sel and pop_ep are already valid endpoint numbers.
module pnq_tx_bank #(
    parameter int NUM_EP = 16,
    parameter int DEPTH  = 5,
    parameter int W      = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [$clog2(NUM_EP)-1:0] sel,
    input  logic [W-1:0]              din,
    input  logic                      pop,
    input  logic [$clog2(NUM_EP)-1:0] pop_ep,
    input  logic [NUM_EP-1:0]         ep_en,
    output logic [W-1:0]              head,
    output logic [2*NUM_EP-1:0]       stat,
    output logic                      push_rej,
    output logic                      pop_rej,
    output logic                      pop_done,
    output logic                      drained
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NUM_EP-1:0] push_v, pop_v, push_ok_v, pop_ok_v, empty_v, full_v;
    logic [W-1:0]      head_a [NUM_EP];
    logic [CW-1:0]     cnt_a  [NUM_EP];

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign push_v[i] = push && (sel == i);
        assign pop_v[i]  = pop && (pop_ep == i);

        pnq_fifo #(.DEPTH(DEPTH), .W(W)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push_v[i]),
            .din     (din),
            .pop     (pop_v[i]),
            .head    (head_a[i]),
            .count   (cnt_a[i]),
            .empty   (empty_v[i]),
            .full    (full_v[i]),
            .push_ok (push_ok_v[i]),
            .pop_ok  (pop_ok_v[i])
        );

        assign stat[2*i]   = empty_v[i];
        assign stat[2*i+1] = full_v[i];
    end

    // Result of the cycle: refusals, pop success, and drain of an enabled queue.
    always_comb begin
        push_rej = push && !(|push_ok_v);
        pop_rej  = pop && !(|pop_ok_v);
        pop_done = |pop_ok_v;
        drained  = pop_ok_v[pop_ep] && ep_en[pop_ep]
                   && (cnt_a[pop_ep] == CW'(1)) && !push_ok_v[pop_ep];
    end

    assign head = head_a[pop_ep];

    p_drain_leaves_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> stat[2*$past(pop_ep)]);
endmodule

// File: rtl/pnq_rx_path.sv
// The shared receive queue. The bus engine offers received packet numbers and
// gets an acknowledge only when there is room. Firmware pops from the head.
// Assumes the bus engine keeps a refused packet and retries it later.
module pnq_rx_path #(
    parameter int DEPTH = 16,
    parameter int W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic                       ack,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       push_rej,
    output logic                       pop_rej
);
    localparam int CW = $clog2(DEPTH + 1);

    logic full, push_ok, pop_ok;

    pnq_fifo #(.DEPTH(DEPTH), .W(W)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .din     (din),
        .pop     (pop),
        .head    (head),
        .count   (count),
        .empty   (empty),
        .full    (full),
        .push_ok (push_ok),
        .pop_ok  (pop_ok)
    );

    // Acknowledge and refusal of the current offer and pop.
    always_comb begin
        ack      = push_ok;
        push_rej = push && full;
        pop_rej  = pop && !pop_ok;
    end

    p_rx_ack_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pop) |=> (count == $past(count) + CW'(1)));
endmodule

// File: rtl/pkt_num_queues.sv
// Top level of the packet number queue bank. It holds the firmware endpoint
// select register, registers the one-cycle events and keeps the sticky errors.
// Assumes one clock domain and a synchronous active-low reset.
module pkt_num_queues
    import pnq_pkg::*;
#(
    parameter int NUM_EP   = PNQ_NUM_EP,
    parameter int TX_DEPTH = PNQ_TX_DEPTH,
    parameter int RX_DEPTH = PNQ_RX_DEPTH,
    parameter int PN_W     = PNQ_PN_W,
    localparam int EP_W    = $clog2(NUM_EP),
    localparam int RXC_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [EP_W-1:0]   sel_ep,
    input  logic              fw_push,
    input  logic [PN_W-1:0]   fw_pn,
    input  logic [NUM_EP-1:0] ep_tx_en,
    input  logic              bus_done,
    input  logic [EP_W-1:0]   bus_ep,
    output logic [PN_W-1:0]   bus_head_pn,
    input  logic              hw_rx_push,
    input  logic [PN_W-1:0]   hw_rx_pn,
    output logic              rx_ack,
    input  logic              fw_rx_pop,
    output logic [PN_W-1:0]   rx_head_pn,
    output logic [RXC_W-1:0]  rx_count,
    output logic              rx_empty,
    output logic [2*NUM_EP-1:0] tx_stat,
    output logic              ev_rx,
    output logic              ev_tx,
    output logic              ev_tx_empty,
    output logic              err_push_full,
    output logic              err_pop_empty
);
    logic [EP_W-1:0] sel_q;
    logic tx_push_rej, tx_pop_rej, tx_pop_done, tx_drained;
    logic rx_push_rej, rx_pop_rej;
    pnq_evt_t evt_q;

    // Endpoint select register for firmware pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= sel_ep;
    end

    pnq_tx_bank #(.NUM_EP(NUM_EP), .DEPTH(TX_DEPTH), .W(PN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fw_push),
        .sel      (sel_q),
        .din      (fw_pn),
        .pop      (bus_done),
        .pop_ep   (bus_ep),
        .ep_en    (ep_tx_en),
        .head     (bus_head_pn),
        .stat     (tx_stat),
        .push_rej (tx_push_rej),
        .pop_rej  (tx_pop_rej),
        .pop_done (tx_pop_done),
        .drained  (tx_drained)
    );

    pnq_rx_path #(.DEPTH(RX_DEPTH), .W(PN_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (hw_rx_push),
        .din      (hw_rx_pn),
        .pop      (fw_rx_pop),
        .ack      (rx_ack),
        .head     (rx_head_pn),
        .count    (rx_count),
        .empty    (rx_empty),
        .push_rej (rx_push_rej),
        .pop_rej  (rx_pop_rej)
    );

    // One-cycle events, registered after the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q.rx       <= rx_ack;
            evt_q.tx       <= tx_pop_done;
            evt_q.tx_drain <= tx_drained;
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_push_full <= 1'b0;
            err_pop_empty <= 1'b0;
        end else begin
            err_push_full <= err_push_full | tx_push_rej | rx_push_rej;
            err_pop_empty <= err_pop_empty | tx_pop_rej | rx_pop_rej;
        end
    end

    assign ev_rx       = evt_q.rx;
    assign ev_tx       = evt_q.tx;
    assign ev_tx_empty = evt_q.tx_drain;

    p_rx_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |-> $past(rx_ack));
    p_tx_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx |-> $past(bus_done));
    p_drain_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |-> (ev_tx && $past(ep_tx_en[bus_ep])));
    p_push_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_push_full |=> err_push_full);
    p_pop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pop_empty |=> err_pop_empty);
endmodule

// File: tb/pkt_num_queues_bench.sv
// Self-checking bench: a behavioural model built on queues, compared every cycle.
module pkt_num_queues_bench;
    localparam int NEP = 16;
    localparam int TXD = 5;
    localparam int RXD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_wr = 0, fw_push = 0, bus_done = 0, hw_rx_push = 0, fw_rx_pop = 0;
    logic [3:0] sel_ep = 0, bus_ep = 0;
    logic [5:0] fw_pn = 0, hw_rx_pn = 0;
    logic [15:0] ep_tx_en = 0;
    logic [5:0] bus_head_pn, rx_head_pn;
    logic [4:0] rx_count;
    logic rx_ack, rx_empty, ev_rx, ev_tx, ev_tx_empty, err_push_full, err_pop_empty;
    logic [31:0] tx_stat;

    pkt_num_queues u_pkt_num_queues (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_ep(sel_ep),
        .fw_push(fw_push), .fw_pn(fw_pn), .ep_tx_en(ep_tx_en),
        .bus_done(bus_done), .bus_ep(bus_ep), .bus_head_pn(bus_head_pn),
        .hw_rx_push(hw_rx_push), .hw_rx_pn(hw_rx_pn), .rx_ack(rx_ack),
        .fw_rx_pop(fw_rx_pop), .rx_head_pn(rx_head_pn), .rx_count(rx_count),
        .rx_empty(rx_empty), .tx_stat(tx_stat), .ev_rx(ev_rx), .ev_tx(ev_tx),
        .ev_tx_empty(ev_tx_empty), .err_push_full(err_push_full),
        .err_pop_empty(err_pop_empty)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned mtx [NEP][$];
    int unsigned mrx [$];
    int unsigned msel = 0;
    bit me_rx = 0, me_tx = 0, me_txe = 0, m_epf = 0, m_epe = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        for (int e = 0; e < NEP; e++) begin
            s[2*e]   = (mtx[e].size() == 0);
            s[2*e+1] = (mtx[e].size() == TXD);
        end
        return s;
    endfunction

    // Drive one cycle at the falling edge, compare, advance the model, wait a cycle.
    task automatic cyc(input bit sw, input int sd, input bit fp, input int fpn,
                       input bit bd, input int be, input bit rp, input int rpn,
                       input bit rpop);
        bit tpush_ok, tpop_ok, rpush_ok, rpop_ok;
        int unsigned tsz, rsz;
        sel_wr = sw; sel_ep = 4'(sd); fw_push = fp; fw_pn = 6'(fpn);
        bus_done = bd; bus_ep = 4'(be); hw_rx_push = rp; hw_rx_pn = 6'(rpn);
        fw_rx_pop = rpop;
        #1;
        chk("R9", "tx_stat", tx_stat, exp_stat());
        chk("R5", "rx_count", 32'(rx_count), 32'(mrx.size()));
        chk("R5", "rx_empty", 32'(rx_empty), 32'(mrx.size() == 0));
        chk("R5", "rx_ack", 32'(rx_ack), 32'(rp && mrx.size() < RXD));
        chk("R6", "ev_rx", 32'(ev_rx), 32'(me_rx));
        chk("R7", "ev_tx", 32'(ev_tx), 32'(me_tx));
        chk("R8", "ev_tx_empty", 32'(ev_tx_empty), 32'(me_txe));
        chk("R3", "err_push_full", 32'(err_push_full), 32'(m_epf));
        chk("R4", "err_pop_empty", 32'(err_pop_empty), 32'(m_epe));
        if (mtx[be].size() != 0) chk("R1", "bus_head_pn", 32'(bus_head_pn), mtx[be][0]);
        if (mrx.size() != 0) chk("R5", "rx_head_pn", 32'(rx_head_pn), mrx[0]);
        // model update, judged on occupancy before the edge
        tsz = mtx[msel].size();
        tpush_ok = fp && (tsz < TXD);
        tpop_ok  = bd && (mtx[be].size() > 0);
        rsz = mrx.size();
        rpush_ok = rp && (rsz < RXD);
        rpop_ok  = rpop && (rsz > 0);
        if ((fp && !tpush_ok) || (rp && !rpush_ok)) m_epf = 1;
        if ((bd && !tpop_ok) || (rpop && !rpop_ok)) m_epe = 1;
        if (tpop_ok) void'(mtx[be].pop_front());
        if (tpush_ok) mtx[msel].push_back(fpn);
        if (rpop_ok) void'(mrx.pop_front());
        if (rpush_ok) mrx.push_back(rpn);
        me_rx = rpush_ok;
        me_tx = tpop_ok;
        me_txe = tpop_ok && ep_tx_en[be] && (mtx[be].size() == 0);
        if (sw) msel = sd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0,0); endtask
    task automatic selw(input int e); cyc(1,e,0,0,0,0,0,0,0); endtask
    task automatic tpush(input int pn); cyc(0,0,1,pn,0,0,0,0,0); endtask
    task automatic tpop(input int e); cyc(0,0,0,0,1,e,0,0,0); endtask

    bit done = 0;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        #1;
        chk("R10", "tx_stat reset", tx_stat, 32'h5555_5555);
        chk("R10", "rx_count reset", 32'(rx_count), 0);
        chk("R10", "flags reset", {27'd0, ev_rx, ev_tx, ev_tx_empty, err_push_full, err_pop_empty}, 0);
        @(negedge clk);
        idle();
        // R1/R3: fill endpoint 3 beyond depth
        ep_tx_en = 16'h0008;
        selw(3);
        for (int i = 1; i <= 6; i++) tpush(i);
        chk("R3", "ep3 full bit", 32'(tx_stat[7]), 1);
        for (int i = 0; i < 5; i++) tpop(3);      // heads 1..5, last drains (R8)
        idle();
        tpop(3);                                  // R4 empty pop
        idle();
        // R8: disabled endpoint never raises drain event
        selw(7); tpush(9); tpop(7); idle();
        // R11: push+pop on partly filled, full and empty queues
        selw(5); tpush(10); tpush(11);
        cyc(0,0,1,12,1,5,0,0,0);
        tpush(13); tpush(14); tpush(15);
        chk("R11", "ep5 full", 32'(tx_stat[11:10]), 32'h2);
        cyc(0,0,1,16,1,5,0,0,0);                  // full: pop ok, push refused
        chk("R11", "ep5 after full push+pop", 32'(tx_stat[11:10]), 32'h0);
        for (int i = 0; i < 4; i++) tpop(5);
        cyc(0,0,1,17,1,5,0,0,0);                  // empty: push ok, pop refused
        chk("R11", "ep5 one entry", 32'(tx_stat[11:10]), 32'h0);
        tpop(5);
        // R2: select write and push in same cycle uses old select (5)
        cyc(1,9,1,20,0,0,0,0,0);
        chk("R2", "old select ep5 not empty", 32'(tx_stat[10]), 0);
        chk("R2", "new select ep9 still empty", 32'(tx_stat[18]), 1);
        tpush(21);
        chk("R2", "ep9 now loaded", 32'(tx_stat[18]), 0);
        tpop(5); tpop(9);
        // R5: fill receive queue, seventeenth refused
        for (int i = 0; i < 17; i++) cyc(0,0,0,0,0,0,1,i+30,0);
        chk("R5", "rx full count", 32'(rx_count), 16);
        cyc(0,0,0,0,0,0,1,60,1);                  // full: pop ok, push refused
        for (int i = 0; i < 16; i++) cyc(0,0,0,0,0,0,0,0,1);
        cyc(0,0,0,0,0,0,1,61,1);                  // empty: push ok, pop refused
        idle();
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) ep_tx_en = 16'($urandom);
            cyc(($urandom % 4) == 0, $urandom % 16, ($urandom % 3) != 0, $urandom % 64,
                ($urandom % 3) == 0, $urandom % 16, ($urandom % 2) == 0, $urandom % 64,
                ($urandom % 2) == 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule